// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block is a synthesizable stand-in for a small three-wire serial EEPROM. The serial clock is the block clock. A host raises the select line and shifts instructions in on the serial data input, most significant bit first. Each bit is sampled on a rising edge. Every instruction opens with a 1 start bit, followed by a two-bit opcode and an address. Any 0 bits on the input before that start bit are ignored.

The storage holds a parameterised number of bytes. A parameter chooses whether it is organised as bytes or as 16-bit words, and the address width follows from that choice. The block supports four operations: read, single-location write, erase/write enable and disable, and erase of the whole array.

A read returns the addressed location and then continues with the following locations for as long as select stays high. Writes and the full erase are gated by an internal write-enable latch. Each programming operation holds the block busy for a while, and the `ready` flag shows when it is free again. Dropping select at any moment abandons whatever was partly received.

Top module: `mw_eeprom`

## Requirements
- R1: After reset, `sdo` is 0, `ready` is 1 and the write-enable latch is clear. The array contents are not touched by reset.
- R2: Zero bits on `sdi` while select is high and no instruction is active are ignored. An instruction begins at the first 1 bit.
- R3: The instruction after the start bit is a 2-bit opcode (10 read, 01 write, 00 special) and then an address of log2(BYTES) bits in byte organisation, or one bit fewer in 16-bit organisation. Each address selects a distinct location.
- R4: A read drives one 0 bit on `sdo` after the last address bit. The addressed word then follows, most significant bit first, with one bit after each further rising edge.
- R5: While select stays high, a read continues with the next address, and it wraps from the last location to location 0.
- R6: With the latch set, a write takes 8 data bits (byte organisation) or 16 data bits (word organisation), MSB first, right after the address, and stores them at that address.
- R7: With the latch clear, a write leaves the array unchanged.
- R8: A special instruction whose two top address bits are 11 sets the latch. Top bits 00 clear it.
- R9: A special instruction with top address bits 10 sets every location to all ones, but only while the latch is set. If the latch is clear, it has no effect and does not make the block busy.
- R10: A completed write or erase drops `ready` for a busy period. Instructions sent while `ready` is low are ignored.
- R11: Dropping select before the last data bit of a write, or inside an instruction, leaves the array unchanged.
- R12: `sdo` is 0 on the cycle after any rising edge at which select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, also the block clock |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Device select, active high |
| sdi | input | 1 | Serial instruction, address and write data |
| sdo | output | 1 | Serial read data, registered |
| ready | output | 1 | 1 when no write or erase is in progress |

## Verification
The bench writes a distinct arithmetic pattern, (37·a+11) mod 256, to all 128 byte locations. Some of these writes are preceded by zero bits, to show that the start-bit hunt is separate from address decoding. A single sequential read over the whole array then separates correct address decoding from aliasing, and it confirms the bit order and the dummy bit. A second read that starts near the top of the array confirms the wrap to location 0.

An erase sweep, and reads of all ones after it, show the erase fill. Writes and erases attempted after reset, after a disable, during the busy period, and with select dropped partway through are each followed by read-backs that must return the value stored before the attempt. This tells gating by the latch apart from gating by the busy period and from abort handling.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_RD_FIRST,
    ST_RD,
    ST_WDATA,
    ST_HOLD
  } mw_state_e;

  localparam logic [1:0] OPC_READ    = 2'b10;
  localparam logic [1:0] OPC_WRITE   = 2'b01;
  localparam logic [1:0] OPC_SPECIAL = 2'b00;

  localparam logic [1:0] SPC_ENABLE  = 2'b11;
  localparam logic [1:0] SPC_DISABLE = 2'b00;
  localparam logic [1:0] SPC_ERASE   = 2'b10;

endpackage

// File: rtl/mw_array.sv
`timescale 1ns/1ps
module mw_array #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mw_busy.sv
`timescale 1ns/1ps
module mw_busy #(
  parameter int AW          = 7,
  parameter int BUSY_CYCLES = 200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_wr,
  input  logic          start_erase,
  output logic          busy,
  output logic          erase_we,
  output logic [AW-1:0] erase_addr
);
  localparam int DEPTH = 1 << AW;
  localparam int TMAX  = (BUSY_CYCLES > DEPTH) ? BUSY_CYCLES : DEPTH;
  localparam int TW    = $clog2(TMAX + 1);

  logic [TW-1:0] remain;
  logic          erasing;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain     <= '0;
      erasing    <= 1'b0;
      erase_addr <= '0;
    end else if (start_erase) begin
      remain     <= TW'(DEPTH);
      erasing    <= 1'b1;
      erase_addr <= '0;
    end else if (start_wr) begin
      remain     <= TW'(BUSY_CYCLES);
      erasing    <= 1'b0;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
      if (erasing) erase_addr <= erase_addr + 1'b1;
      if (remain == TW'(1)) erasing <= 1'b0;
    end
  end

  assign busy     = (remain != '0);
  assign erase_we = erasing && busy;

  AST_ERASE_SWEEP_START: assert property (@(posedge clk) disable iff (rst)
    start_erase |=> (erase_we && erase_addr == '0)); // R9
endmodule

// File: rtl/mw_eeprom.sv
`timescale 1ns/1ps
module mw_eeprom
  import mw_pkg::*;
#(
  parameter int BYTES       = 128,
  parameter bit WORD_ORG    = 1'b0,
  parameter int BUSY_CYCLES = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic sel,
  input  logic sdi,
  output logic sdo,
  output logic ready
);
  localparam int DW    = WORD_ORG ? 16 : 8;
  localparam int DEPTH = BYTES / (DW / 8);
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = AW + 2;
  localparam int MAXB  = (CW > DW) ? CW : DW;
  localparam int CNTW  = $clog2(MAXB + 1);
  localparam logic [CNTW-1:0] CMD_LAST  = CNTW'(CW - 1);
  localparam logic [CNTW-1:0] WORD_LAST = CNTW'(DW - 1);

  mw_state_e       state;
  logic [CNTW-1:0] cnt;
  logic [CW-2:0]   cmd_sr;
  logic [AW-1:0]   wr_addr;
  logic [DW-2:0]   wr_sr;
  logic [DW-1:0]   out_sr;
  logic [AW-1:0]   ptr;
  logic            wel;

  logic [CW-1:0]   full_cmd;
  logic [1:0]      opc;
  logic [AW-1:0]   cmd_addr;
  logic [1:0]      spc;
  logic            cmd_last;
  logic            commit_wr;
  logic            start_erase;
  logic            busy;
  logic            erase_we;
  logic [AW-1:0]   erase_addr;
  logic            mem_we;
  logic [AW-1:0]   mem_waddr;
  logic [DW-1:0]   mem_wdata;
  logic [AW-1:0]   mem_raddr;
  logic [DW-1:0]   mem_rdata;

  // Decode of the word assembled so far plus the bit on the wire now
  assign full_cmd = {cmd_sr, sdi};
  assign opc      = full_cmd[CW-1 -: 2];
  assign cmd_addr = full_cmd[AW-1:0];
  assign spc      = cmd_addr[AW-1 -: 2];
  assign cmd_last = sel && (state == ST_CMD) && (cnt == CMD_LAST);

  assign commit_wr   = sel && (state == ST_WDATA) && (cnt == WORD_LAST) && wel;
  assign start_erase = cmd_last && (opc == OPC_SPECIAL) && (spc == SPC_ERASE) && wel;

  assign mem_raddr = cmd_last ? cmd_addr : ptr;
  assign mem_we    = commit_wr || erase_we;
  assign mem_waddr = erase_we ? erase_addr : wr_addr;
  assign mem_wdata = erase_we ? {DW{1'b1}} : {wr_sr, sdi};

  mw_array #(.AW(AW), .DW(DW)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  mw_busy #(.AW(AW), .BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk         (clk),
    .rst         (rst),
    .start_wr    (commit_wr),
    .start_erase (start_erase),
    .busy        (busy),
    .erase_we    (erase_we),
    .erase_addr  (erase_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      cmd_sr  <= '0;
      wr_addr <= '0;
      wr_sr   <= '0;
      out_sr  <= '0;
      ptr     <= '0;
      wel     <= 1'b0;
    end else if (!sel) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      out_sr <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (sdi && !busy) begin
            state <= ST_CMD;
            cnt   <= '0;
          end
        end
        ST_CMD: begin
          cmd_sr <= full_cmd[CW-2:0];
          cnt    <= cnt + 1'b1;
          if (cnt == CMD_LAST) begin
            cnt <= '0;
            case (opc)
              OPC_READ: begin
                state <= ST_RD_FIRST;
                ptr   <= cmd_addr;
              end
              OPC_WRITE: begin
                state   <= ST_WDATA;
                wr_addr <= cmd_addr;
              end
              OPC_SPECIAL: begin
                state <= ST_HOLD;
                if (spc == SPC_ENABLE)  wel <= 1'b1;
                if (spc == SPC_DISABLE) wel <= 1'b0;
              end
              default: state <= ST_HOLD;
            endcase
          end
        end
        ST_RD_FIRST: begin
          out_sr <= mem_rdata;
          ptr    <= ptr + 1'b1;
          cnt    <= '0;
          state  <= ST_RD;
        end
        ST_RD: begin
          if (cnt == WORD_LAST) begin
            out_sr <= mem_rdata;
            ptr    <= ptr + 1'b1;
            cnt    <= '0;
          end else begin
            out_sr <= {out_sr[DW-2:0], 1'b0};
            cnt    <= cnt + 1'b1;
          end
        end
        ST_WDATA: begin
          wr_sr <= {wr_sr[DW-3:0], sdi};
          cnt   <= cnt + 1'b1;
          if (cnt == WORD_LAST) state <= ST_HOLD;
        end
        ST_HOLD: state <= ST_HOLD;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sdo   = out_sr[DW-1];
  assign ready = !busy;

  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wel && ready && !sdo)); // R1
  AST_DUMMY_LOW: assert property (@(posedge clk) disable iff (rst)
    (state == ST_RD_FIRST) |-> !sdo); // R4
  AST_ERASE_GATED: assert property (@(posedge clk) disable iff (rst)
    erase_we |-> wel); // R9
  AST_WRITE_BUSY: assert property (@(posedge clk) disable iff (rst)
    commit_wr |=> !ready); // R10
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
    (busy && state == ST_IDLE) |=> (state == ST_IDLE)); // R10
  AST_QUIET_DESELECT: assert property (@(posedge clk) disable iff (rst)
    !sel |=> !sdo); // R12
endmodule

// File: tb/test_mw_eeprom.sv
`timescale 1ns/1ps
module test_mw_eeprom;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0;
  logic sdi = 1'b0;
  logic sdo;
  logic ready;
  int   checks = 0;
  int   errors = 0;
  logic [7:0] model [128];

  always #2.5 clk = ~clk;

  mw_eeprom #(.BYTES(128), .WORD_ORG(1'b0), .BUSY_CYCLES(40)) i_mw_eeprom (
    .clk(clk), .rst(rst), .sel(sel), .sdi(sdi), .sdo(sdo), .ready(ready)
  );

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bit_out(logic b);
    @(negedge clk);
    sel = 1'b1;
    sdi = b;
  endtask

  task automatic deselect();
    @(negedge clk);
    sel = 1'b0;
    sdi = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_cmd(logic [1:0] op, logic [6:0] a);
    bit_out(1'b1);
    for (int i = 1; i >= 0; i--) bit_out(op[i]);
    for (int i = 6; i >= 0; i--) bit_out(a[i]);
  endtask

  task automatic wait_ready();
    while (!ready) @(negedge clk);
  endtask

  task automatic do_write(logic [6:0] a, logic [7:0] d);
    send_cmd(2'b01, a);
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    deselect();
    wait_ready();
  endtask

  task automatic special(logic [1:0] code);
    send_cmd(2'b00, {code, 5'b0});
    deselect();
    wait_ready();
  endtask

  task automatic start_read(logic [6:0] a);
    send_cmd(2'b10, a);
    @(negedge clk);
    check("R4 dummy bit", 32'(sdo), 32'd0);
  endtask

  task automatic read_word(output logic [7:0] w);
    w = '0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      w = {w[6:0], sdo};
    end
  endtask

  task automatic read_one(logic [6:0] a, string req, logic [7:0] exp);
    logic [7:0] w;
    start_read(a);
    read_word(w);
    deselect();
    check(req, 32'(w), 32'(exp));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] w;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 sdo after reset", 32'(sdo), 32'd0);
    check("R1 ready after reset", 32'(ready), 32'd1);

    // R9: enable then erase whole array, expect busy then all ones
    special(2'b11);
    send_cmd(2'b00, 7'b1000000);
    deselect();
    check("R9 erase busy", 32'(ready), 32'd0);
    wait_ready();
    start_read(7'd0);
    for (int a = 0; a < 129; a++) begin
      read_word(w);
      check("R9 erased word", 32'(w), 32'hFF);
    end
    deselect();
    check("R12 sdo low when deselected", 32'(sdo), 32'd0);

    // R1: reset clears the latch, array kept
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    do_write(7'd9, 8'h00);
    read_one(7'd9, "R1 latch clear after reset", 8'hFF);

    // R8 / R7: enable, write, disable, refused write
    special(2'b11);
    do_write(7'd10, 8'h3C);
    read_one(7'd10, "R8 write after enable", 8'h3C);
    special(2'b00);
    do_write(7'd10, 8'h00);
    read_one(7'd10, "R7 write refused after disable", 8'h3C);

    // R6 / R2 / R3: exhaustive write, some with leading zeros
    special(2'b11);
    for (int a = 0; a < 128; a++) begin
      if (a % 16 == 3) begin
        bit_out(1'b0); bit_out(1'b0); bit_out(1'b0);
      end
      do_write(7'(a), pat(a));
      model[a] = pat(a);
    end
    start_read(7'd0);
    for (int a = 0; a < 128; a++) begin
      read_word(w);
      check("R3 R6 R2 sequential word", 32'(w), 32'(model[a]));
    end
    deselect();

    // R5: wrap from top to location 0
    start_read(7'd120);
    for (int k = 0; k < 16; k++) begin
      read_word(w);
      check("R5 wrap read", 32'(w), 32'(model[(120 + k) % 128]));
    end
    deselect();

    // R10: instruction during busy is ignored
    send_cmd(2'b01, 7'd50);
    for (int i = 7; i >= 0; i--) bit_out(model[50][i]);
    deselect();
    check("R10 ready low after write", 32'(ready), 32'd0);
    send_cmd(2'b01, 7'd51);
    for (int i = 7; i >= 0; i--) bit_out(~model[51][i]);
    deselect();
    check("R10 still busy", 32'(ready), 32'd0);
    wait_ready();
    read_one(7'd51, "R10 busy write ignored", model[51]);

    // R11: aborts
    send_cmd(2'b01, 7'd7);
    for (int i = 0; i < 4; i++) bit_out(1'b0);
    deselect();
    check("R11 no busy after abort", 32'(ready), 32'd1);
    read_one(7'd7, "R11 abort in data", model[7]);
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    deselect();
    read_one(7'd8, "R11 abort in command", model[8]);

    // R9: erase refused with latch clear
    special(2'b00);
    send_cmd(2'b00, 7'b1000000);
    deselect();
    check("R9 refused erase not busy", 32'(ready), 32'd1);
    start_read(7'd0);
    for (int a = 0; a < 4; a++) begin
      read_word(w);
      check("R9 refused erase keeps data", 32'(w), 32'(model[a]));
    end
    deselect();
    check("R12 sdo low after read", 32'(sdo), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule